// File: doc/BRIEF.md
# Serial Flash Instruction Front End

This block is the slave side of a serial NOR flash model. A host drives a four-wire serial bus: a select line, a clock, a data-in line and a data-out line. The block rebuilds each instruction from the bits on that bus and carries it out. It returns status, identification and array bytes. It also passes program, erase and status-write requests to an internal status unit and a small byte array. The serial lines are oversampled by a fast system clock. Input bits are taken on the rising serial clock edge, and output bits change on the falling edge. The serial clock may idle either low or high.

Write-class instructions (program, erase, status write, latch set and clear, sleep) only take effect when the select line rises exactly at a byte boundary. A flash cycle that is in progress is modelled by a busy counter, and the sleep state ends through a wake counter. Page loads stay inside one 256-byte page, and programming clears bits only.

Top module: `flash_cmd_engine`

## Requirements
- R1: An instruction starts when select falls. Its first eight input bits, MSB first, form the opcode. An opcode outside the supported set (06, 04, 05, 01, 03, 0B, 02, D8, C7, B9, AB, 90, 9F hex) produces no output and changes no state.
- R2: Opcode 03h takes a 3-byte address, MSB first, and then streams array bytes MSB first. The address rises by one after each byte and wraps at the end of the modelled array.
- R3: Opcode 0Bh behaves like 03h, except that one don't-care byte follows the address before data starts.
- R4: A write-class instruction commits only if select rises after a whole number of bytes and all of its fields have arrived. A partial final byte discards the instruction.
- R5: The write latch (status bit 1) is set by 06h and cleared by 04h. Opcodes 01h, 02h, D8h and C7h are refused while it is clear. It clears itself when a busy cycle ends.
- R6: Page program (02h) loads bytes from the start address. The low 8 address bits wrap inside the page, and a later byte for the same offset replaces an earlier one. On commit, only the loaded offsets of that page are ANDed with the loaded data.
- R7: Opcode D8h sets every byte of the addressed SECTOR_BYTES sector to FFh. Opcode C7h sets the whole array to FFh.
- R8: After a committed program, erase or status write, status bit 0 reads 1 for BUSY_CYCLES system clocks. During that time only 05h is accepted, and a read gives no output.
- R9: Opcode B9h enters sleep, in which only ABh is accepted (05h included among the ignored opcodes). ABh in sleep starts a WAKE_CYCLES wait when select rises, and the block stays asleep until the wait ends.
- R10: Opcode 9Fh returns EFh, 20h, 14h and then repeats. Opcode 90h with a 3-byte address returns EFh and then DEV_ID when address bit 0 is 0, and the reverse order when it is 1, alternating after that. Opcode ABh returns DEV_ID after three dummy bytes.
- R11: Status byte layout: bit 7 lock bit, bits 6:5 zero, bits 4:2 protect field, bit 1 write latch, bit 0 busy. Opcode 01h writes only bits 7 and 4:2. A nonzero protect field refuses program and erase.
- R12: The output enable is low whenever select is high or no output phase is active. Data out changes only after a falling serial clock edge. Both idle clock levels work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for spi_miso; low means high impedance |

## Verification
The assertions assume that the serial lines change only well away from system clock edges. They also assume each serial clock half period lasts several system clocks, so that a received byte is decoded before the next falling edge. Select must stay high for at least two system clocks and must never rise in the same cycle that a byte completes. The stimulus drives every line on the falling system clock edge and holds each serial half period for four system clocks. It also waits several cycles around every select transition, so all of these conditions hold throughout the run.

// File: rtl/fcmd_pkg.sv
// Shared opcodes, decoder phases and commit kinds for the flash front end.
package fcmd_pkg;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_WRDI   = 8'h04;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_WRSR   = 8'h01;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_FREAD  = 8'h0B;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_SERASE = 8'hD8;
    localparam logic [7:0] OP_CERASE = 8'hC7;
    localparam logic [7:0] OP_SLEEP  = 8'hB9;
    localparam logic [7:0] OP_WAKEID = 8'hAB;
    localparam logic [7:0] OP_MFID   = 8'h90;
    localparam logic [7:0] OP_JEDEC  = 8'h9F;
    localparam int PAGE_BYTES = 256;

    typedef enum logic [2:0] {PH_OP, PH_ADDR, PH_DUMMY, PH_OUT, PH_IN, PH_END, PH_SKIP} phase_t;
    typedef enum logic [3:0] {K_NONE, K_WREN, K_WRDI, K_WRSR, K_PROG, K_SERASE,
                              K_CERASE, K_SLEEP, K_WAKE} commit_t;
endpackage

// File: rtl/fcmd_spi_front.sv
// Serial front end: oversamples the serial lines, assembles input bytes on
// rising clock edges and shifts output bits on falling edges.
// Assumes the serial half period spans several system clocks.
module fcmd_spi_front (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    input  logic       tx_en,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       cs_rise,
    output logic       aligned,
    output logic       miso
);
    logic       sck_q, cs_q;
    logic [2:0] bitcnt;
    logic [6:0] shreg;
    logic       sck_up, sck_dn;

    assign sck_up  = sck & ~sck_q & ~cs_n;
    assign sck_dn  = ~sck & sck_q & ~cs_n;
    assign cs_rise = cs_n & ~cs_q;
    assign aligned = (bitcnt == 3'd0);

    // Edge history, input shift register and output bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q    <= 1'b0;
            cs_q     <= 1'b1;
            bitcnt   <= '0;
            shreg    <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
            miso     <= 1'b0;
        end else begin
            sck_q    <= sck;
            cs_q     <= cs_n;
            rx_valid <= 1'b0;
            if (cs_n) begin
                bitcnt <= '0;
            end else if (sck_up) begin
                shreg  <= {shreg[5:0], mosi};
                bitcnt <= bitcnt + 3'd1;
                if (bitcnt == 3'd7) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {shreg, mosi};
                end
            end
            if (sck_dn && tx_en)
                miso <= tx_byte[3'd7 - bitcnt];
        end
    end

    // R1: a byte is only assembled while select is low
    a_r1_rx_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(!cs_n));
    // R12: data out moves only after a falling serial clock edge
    a_r12_do_on_falling: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> ($past(sck_q) && !$past(sck)));
endmodule

// File: rtl/fcmd_decoder.sv
// Instruction decoder: tracks opcode, address, dummy and data phases, picks
// the output byte and issues a commit kind when select rises.
// Assumes select never rises in the cycle a byte completes.
module fcmd_decoder
    import fcmd_pkg::*;
#(
    parameter int         AW       = 9,
    parameter logic [7:0] MFR_ID   = 8'hEF,
    parameter logic [7:0] MEM_TYPE = 8'h20,
    parameter logic [7:0] CAPACITY = 8'h14,
    parameter logic [7:0] DEV_ID   = 8'h13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_byte,
    input  logic          cs_rise,
    input  logic          aligned,
    input  logic          busy,
    input  logic          sleep,
    input  logic [7:0]    status,
    input  logic [7:0]    rd_data,
    output logic [7:0]    tx_byte,
    output logic          tx_en,
    output logic [AW-1:0] addr_out,
    output commit_t       commit,
    output logic [3:0]    sr_bits,
    output logic          buf_we,
    output logic          buf_clear,
    output logic [7:0]    buf_idx,
    output logic [7:0]    buf_data
);
    phase_t      phase;
    logic [7:0]  op;
    logic [23:0] addr;
    logic [1:0]  cnt, idx;
    logic        got, wake_req, accept;
    logic [1:0]  dummy_last;

    function automatic logic known_op(input logic [7:0] b);
        case (b)
            OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR, OP_READ, OP_FREAD, OP_PROG,
            OP_SERASE, OP_CERASE, OP_SLEEP, OP_WAKEID, OP_MFID, OP_JEDEC: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    assign accept     = sleep ? (rx_byte == OP_WAKEID) :
                        busy  ? (rx_byte == OP_RDSR) : known_op(rx_byte);
    assign dummy_last = (op == OP_FREAD) ? 2'd0 : 2'd2;
    assign tx_en      = (phase == PH_OUT);
    assign addr_out   = addr[AW-1:0];

    // Output byte selection for the active read-type opcode.
    always_comb begin
        case (op)
            OP_RDSR:            tx_byte = status;
            OP_READ, OP_FREAD:  tx_byte = rd_data;
            OP_JEDEC:           tx_byte = (idx == 2'd0) ? MFR_ID : (idx == 2'd1) ? MEM_TYPE : CAPACITY;
            OP_MFID:            tx_byte = (addr[0] ^ idx[0]) ? DEV_ID : MFR_ID;
            default:            tx_byte = DEV_ID;
        endcase
    end

    // Phase sequencing per received byte and commit at select rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_OP;  op <= '0;  addr <= '0;  cnt <= '0;  idx <= '0;
            got <= 1'b0;  wake_req <= 1'b0;  commit <= K_NONE;  sr_bits <= '0;
            buf_we <= 1'b0;  buf_clear <= 1'b0;  buf_idx <= '0;  buf_data <= '0;
        end else begin
            commit    <= K_NONE;
            buf_we    <= 1'b0;
            buf_clear <= 1'b0;
            if (cs_rise) begin
                phase <= PH_OP;  cnt <= '0;  idx <= '0;  got <= 1'b0;  wake_req <= 1'b0;
                if (wake_req)
                    commit <= K_WAKE;
                else if (phase == PH_END && aligned)
                    case (op)
                        OP_WREN:   commit <= K_WREN;
                        OP_WRDI:   commit <= K_WRDI;
                        OP_CERASE: commit <= K_CERASE;
                        OP_SLEEP:  commit <= K_SLEEP;
                        OP_SERASE: commit <= K_SERASE;
                        default:   commit <= K_NONE;
                    endcase
                else if (phase == PH_IN && got && aligned)
                    commit <= (op == OP_WRSR) ? K_WRSR : K_PROG;
            end else if (rx_valid) begin
                case (phase)
                    PH_OP: begin
                        op <= rx_byte;
                        if (!accept) phase <= PH_SKIP;
                        else case (rx_byte)
                            OP_WREN, OP_WRDI, OP_CERASE, OP_SLEEP: phase <= PH_END;
                            OP_RDSR, OP_JEDEC:                     phase <= PH_OUT;
                            OP_WRSR:                               phase <= PH_IN;
                            OP_WAKEID: begin
                                phase    <= PH_DUMMY;
                                wake_req <= sleep;
                            end
                            default:                               phase <= PH_ADDR;
                        endcase
                        buf_clear <= accept && (rx_byte == OP_PROG);
                    end
                    PH_ADDR: begin
                        addr <= {addr[15:0], rx_byte};
                        cnt  <= cnt + 2'd1;
                        if (cnt == 2'd2) begin
                            cnt <= '0;
                            case (op)
                                OP_FREAD:  phase <= PH_DUMMY;
                                OP_PROG:   phase <= PH_IN;
                                OP_SERASE: phase <= PH_END;
                                default:   phase <= PH_OUT;
                            endcase
                        end
                    end
                    PH_DUMMY: begin
                        cnt <= cnt + 2'd1;
                        if (cnt == dummy_last) begin
                            cnt   <= '0;
                            phase <= PH_OUT;
                        end
                    end
                    PH_OUT: begin
                        if (op == OP_READ || op == OP_FREAD) addr <= addr + 24'd1;
                        idx <= (op == OP_JEDEC && idx == 2'd2) ? 2'd0 : idx + 2'd1;
                    end
                    PH_IN: begin
                        got <= 1'b1;
                        if (op == OP_PROG) begin
                            buf_we      <= 1'b1;
                            buf_idx     <= addr[7:0];
                            buf_data    <= rx_byte;
                            addr[7:0]   <= addr[7:0] + 8'd1;
                        end else begin
                            sr_bits <= {rx_byte[7], rx_byte[4:2]};
                        end
                    end
                    PH_END:  phase <= PH_SKIP;
                    default: phase <= PH_SKIP;
                endcase
            end
        end
    end

    // R6: page loads only happen after a program opcode reset the load map
    a_r6_load_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (op == OP_PROG));
endmodule

// File: rtl/fcmd_status.sv
// Status and protection unit: write latch, protect field, lock bit, busy
// and wake counters; gates array operations on latch and protection.
// Assumes commits arrive only from the decoder's gating rules.
module fcmd_status
    import fcmd_pkg::*;
#(
    parameter int BUSY_CYCLES = 600,
    parameter int WAKE_CYCLES = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  commit_t    commit,
    input  logic [3:0] sr_bits,
    output logic [7:0] status,
    output logic       busy,
    output logic       sleep,
    output logic       go_prog,
    output logic       go_serase,
    output logic       go_cerase
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);
    localparam int WW = $clog2(WAKE_CYCLES + 1);

    logic          wel, lock;
    logic [2:0]    prot;
    logic [BW-1:0] bcnt;
    logic [WW-1:0] wcnt;
    logic          may_write;

    assign busy      = (bcnt != '0);
    assign status    = {lock, 2'b00, prot, wel, busy};
    assign may_write = wel && (prot == 3'b000);

    // Latch, protection, busy and wake bookkeeping per commit kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0;  lock <= 1'b0;  prot <= '0;  bcnt <= '0;  wcnt <= '0;
            sleep <= 1'b0;  go_prog <= 1'b0;  go_serase <= 1'b0;  go_cerase <= 1'b0;
        end else begin
            go_prog   <= 1'b0;
            go_serase <= 1'b0;
            go_cerase <= 1'b0;
            if (bcnt != '0) begin
                bcnt <= bcnt - 1'b1;
                if (bcnt == BW'(1)) wel <= 1'b0;
            end
            if (wcnt != '0) begin
                wcnt <= wcnt - 1'b1;
                if (wcnt == WW'(1)) sleep <= 1'b0;
            end
            case (commit)
                K_WREN:  wel <= 1'b1;
                K_WRDI:  wel <= 1'b0;
                K_WRSR:  if (wel) begin
                    lock <= sr_bits[3];
                    prot <= sr_bits[2:0];
                    bcnt <= BW'(BUSY_CYCLES);
                end
                K_PROG:   if (may_write) begin go_prog   <= 1'b1; bcnt <= BW'(BUSY_CYCLES); end
                K_SERASE: if (may_write) begin go_serase <= 1'b1; bcnt <= BW'(BUSY_CYCLES); end
                K_CERASE: if (may_write) begin go_cerase <= 1'b1; bcnt <= BW'(BUSY_CYCLES); end
                K_SLEEP:  sleep <= 1'b1;
                K_WAKE:   wcnt  <= WW'(WAKE_CYCLES);
                default: ;
            endcase
        end
    end

    // R8: no array operation is launched while a busy cycle runs
    a_r8_no_op_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !(go_prog || go_serase || go_cerase));
    // R5: the write latch is clear once a busy cycle has ended
    a_r5_latch_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !status[1]);
    // R9: sleep is never entered with a flash cycle running
    a_r9_sleep_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !busy);
endmodule

// File: rtl/fcmd_array.sv
// Byte array model with a one-page load buffer: program ANDs loaded offsets
// into one page, sector and chip erase set bytes to FFh.
// Assumes MEM_BYTES is a multiple of the page size and at least two pages.
module fcmd_array
    import fcmd_pkg::*;
#(
    parameter int MEM_BYTES    = 512,
    parameter int SECTOR_BYTES = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(MEM_BYTES)-1:0] addr,
    input  logic                         buf_we,
    input  logic                         buf_clear,
    input  logic [7:0]                   buf_idx,
    input  logic [7:0]                   buf_data,
    input  logic                         go_prog,
    input  logic                         go_serase,
    input  logic                         go_cerase,
    output logic [7:0]                   rd_data
);
    localparam int AW = $clog2(MEM_BYTES);

    logic [7:0]            mem  [MEM_BYTES];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pval;

    assign rd_data = mem[addr];

    // Page load buffer contents (no reset needed: gated by the valid map).
    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_idx] <= buf_data;
    end

    // Valid map and array updates for program and erase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pval <= '0;
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
        end else begin
            if (buf_clear)   pval <= '0;
            else if (buf_we) pval[buf_idx] <= 1'b1;
            for (int i = 0; i < MEM_BYTES; i++) begin
                if (go_cerase)
                    mem[i] <= 8'hFF;
                else if (go_serase && (i / SECTOR_BYTES) == (int'(addr) / SECTOR_BYTES))
                    mem[i] <= 8'hFF;
                else if (go_prog && (i / PAGE_BYTES) == int'(addr[AW-1:8]) && pval[i % PAGE_BYTES])
                    mem[i] <= mem[i] & pbuf[i % PAGE_BYTES];
            end
        end
    end

    // R7: erase commands are exclusive with a program launch
    a_r7_ops_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({go_prog, go_serase, go_cerase}));
endmodule

// File: rtl/flash_cmd_engine.sv
// Top of the serial flash instruction front end: serial front, decoder,
// status/protection unit and array model.
// Assumes select stays high for at least two system clocks.
module flash_cmd_engine
    import fcmd_pkg::*;
#(
    parameter int         MEM_BYTES    = 512,
    parameter int         SECTOR_BYTES = 256,
    parameter int         BUSY_CYCLES  = 600,
    parameter int         WAKE_CYCLES  = 200,
    parameter logic [7:0] DEV_ID       = 8'h13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);
    localparam int AW = $clog2(MEM_BYTES);

    logic          rx_valid, cs_rise, aligned, tx_en;
    logic [7:0]    rx_byte, tx_byte, status, rd_data, buf_idx, buf_data;
    logic          busy, sleep, buf_we, buf_clear, go_prog, go_serase, go_cerase;
    logic [AW-1:0] addr;
    logic [3:0]    sr_bits;
    commit_t       commit;

    assign spi_miso_oe = ~spi_cs_n & tx_en;

    fcmd_spi_front u_front (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .tx_byte(tx_byte), .tx_en(tx_en), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .cs_rise(cs_rise), .aligned(aligned), .miso(spi_miso));

    fcmd_decoder #(.AW(AW), .DEV_ID(DEV_ID)) u_dec (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .cs_rise(cs_rise), .aligned(aligned), .busy(busy), .sleep(sleep),
        .status(status), .rd_data(rd_data), .tx_byte(tx_byte), .tx_en(tx_en),
        .addr_out(addr), .commit(commit), .sr_bits(sr_bits), .buf_we(buf_we),
        .buf_clear(buf_clear), .buf_idx(buf_idx), .buf_data(buf_data));

    fcmd_status #(.BUSY_CYCLES(BUSY_CYCLES), .WAKE_CYCLES(WAKE_CYCLES)) u_stat (
        .clk(clk), .rst_n(rst_n), .commit(commit), .sr_bits(sr_bits),
        .status(status), .busy(busy), .sleep(sleep), .go_prog(go_prog),
        .go_serase(go_serase), .go_cerase(go_cerase));

    fcmd_array #(.MEM_BYTES(MEM_BYTES), .SECTOR_BYTES(SECTOR_BYTES)) u_arr (
        .clk(clk), .rst_n(rst_n), .addr(addr), .buf_we(buf_we), .buf_clear(buf_clear),
        .buf_idx(buf_idx), .buf_data(buf_data), .go_prog(go_prog),
        .go_serase(go_serase), .go_cerase(go_cerase), .rd_data(rd_data));

    // R4: a commit is only produced once select has gone high
    a_r4_commit_after_select: assert property (@(posedge clk) disable iff (!rst_n)
        (commit != K_NONE) |-> spi_cs_n);
endmodule

// File: tb/flash_cmd_engine_bench.sv
module flash_cmd_engine_bench;
    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, oe;
    logic idle_lvl = 1'b0;
    logic last_oe;
    int   n_chk = 0, n_fail = 0;
    localparam logic [7:0] DEV = 8'h13;

    always #5 clk = ~clk;

    flash_cmd_engine #(.BUSY_CYCLES(600), .WAKE_CYCLES(200), .DEV_ID(DEV)) u_flash_cmd_engine (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(oe));

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic sel();
        cs_n = 1'b0; wclk(4);
    endtask

    task automatic desel();
        wclk(2); sck = idle_lvl; wclk(4); cs_n = 1'b1; wclk(6);
    endtask

    task automatic bits(input logic [7:0] d, input int n, output logic [7:0] r);
        r = '0;
        for (int i = 0; i < n; i++) begin
            sck = 1'b0; mosi = d[7 - i]; wclk(4);
            sck = 1'b1; wclk(2);
            r = {r[6:0], miso}; last_oe = oe;
            wclk(2);
        end
    endtask

    task automatic xb(input logic [7:0] d, output logic [7:0] r);
        bits(d, 8, r);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        sel(); xb(op, r); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] r;
        sel(); xb(8'h05, r); xb(8'h00, s); desel();
    endtask

    task automatic wait_ready();
        logic [7:0] s;
        for (int i = 0; i < 40; i++) begin
            rdsr(s);
            if (!s[0]) break;
        end
    endtask

    task automatic addr3(input logic [23:0] a);
        logic [7:0] r;
        xb(a[23:16], r); xb(a[15:8], r); xb(a[7:0], r);
    endtask

    task automatic rd1(input logic [23:0] a, output logic [7:0] d);
        logic [7:0] r;
        sel(); xb(8'h03, r); addr3(a); xb(8'h00, d); desel();
    endtask

    task automatic t_reset();
        logic [7:0] s;
        chk("R12 oe idle", {7'd0, oe}, 8'h00);
        rdsr(s); chk("R11 reset status", s, 8'h00);
    endtask

    task automatic t_ids();
        logic [7:0] r, d;
        sel(); xb(8'h9F, r);
        xb(0, d); chk("R10 jedec0", d, 8'hEF);
        xb(0, d); chk("R10 jedec1", d, 8'h20);
        xb(0, d); chk("R10 jedec2", d, 8'h14);
        xb(0, d); chk("R10 jedec wrap", d, 8'hEF);
        desel();
        sel(); xb(8'h90, r); addr3(24'h0);
        xb(0, d); chk("R10 mfid a0 first", d, 8'hEF);
        xb(0, d); chk("R10 mfid a0 second", d, DEV);
        xb(0, d); chk("R10 mfid a0 third", d, 8'hEF);
        desel();
        sel(); xb(8'h90, r); addr3(24'h1);
        xb(0, d); chk("R10 mfid a1 first", d, DEV);
        xb(0, d); chk("R10 mfid a1 second", d, 8'hEF);
        desel();
        sel(); xb(8'hAB, r); addr3(24'h0); xb(0, d); chk("R10 devid", d, DEV); desel();
    endtask

    task automatic t_latch();
        logic [7:0] s, r;
        sel(); xb(8'h06, r); bits(8'h00, 1, r); desel();
        rdsr(s); chk("R4 partial wren dropped", s, 8'h00);
        cmd1(8'h06); rdsr(s); chk("R5 wren sets latch", s, 8'h02);
        cmd1(8'h04); rdsr(s); chk("R5 wrdi clears latch", s, 8'h00);
        sel(); xb(8'h02, r); addr3(24'h0); xb(8'h00, r); desel();
        rd1(24'h0, r); chk("R5 program refused without latch", r, 8'hFF);
    endtask

    task automatic t_program();
        logic [7:0] r, s, d;
        cmd1(8'h06);
        sel(); xb(8'h02, r); addr3(24'h1F0);
        for (int k = 0; k < 20; k++) xb(8'h40 + 8'(k), r);
        desel();
        rdsr(s); chk("R8 busy during program", s, 8'h03);
        rd1(24'h1F0, d); chk("R8 read ignored while busy", {7'd0, last_oe}, 8'h00);
        wait_ready();
        rdsr(s); chk("R5 latch cleared after cycle", s, 8'h00);
        rd1(24'h1FF, d); chk("R6 page end byte", d, 8'h4F);
        rd1(24'h100, d); chk("R6 wrapped byte", d, 8'h50);
        rd1(24'h103, d); chk("R6 last wrapped byte", d, 8'h53);
        rd1(24'h104, d); chk("R6 untouched byte", d, 8'hFF);
        cmd1(8'h06);
        sel(); xb(8'h02, r); addr3(24'h000);
        for (int k = 0; k < 257; k++) xb((k < 256) ? 8'(k) : 8'h77, r);
        desel(); wait_ready();
        rd1(24'h000, d); chk("R6 overwrite after wrap", d, 8'h77);
        rd1(24'h001, d); chk("R6 second offset", d, 8'h01);
        cmd1(8'h06);
        sel(); xb(8'h02, r); addr3(24'h100); xb(8'h0F, r); desel(); wait_ready();
        rd1(24'h100, d); chk("R6 program ANDs", d, 8'h00);
        rd1(24'h101, d); chk("R6 neighbour kept", d, 8'h51);
    endtask

    task automatic t_reads();
        logic [7:0] r, d;
        sel(); xb(8'h03, r); addr3(24'h1FE);
        xb(0, d); chk("R2 stream 0", d, 8'h4E);
        xb(0, d); chk("R2 stream 1", d, 8'h4F);
        xb(0, d); chk("R2 wrap to 0", d, 8'h77);
        desel();
        sel(); xb(8'h0B, r); addr3(24'h101); xb(8'hA5, r);
        xb(0, d); chk("R3 fast read first", d, 8'h51);
        xb(0, d); chk("R3 fast read next", d, 8'h52);
        desel();
    endtask

    task automatic t_partial_prog();
        logic [7:0] r, s, d;
        cmd1(8'h06);
        sel(); xb(8'h02, r); addr3(24'h104); xb(8'h00, r); bits(8'h00, 3, r); desel();
        rdsr(s); chk("R4 partial program not busy", s, 8'h02);
        rd1(24'h104, d); chk("R4 partial program dropped", d, 8'hFF);
        cmd1(8'h04);
    endtask

    task automatic t_erase_protect();
        logic [7:0] r, s, d;
        cmd1(8'h06);
        sel(); xb(8'hD8, r); addr3(24'h100); desel(); wait_ready();
        rd1(24'h101, d); chk("R7 sector erased", d, 8'hFF);
        rd1(24'h001, d); chk("R7 other sector kept", d, 8'h01);
        cmd1(8'h06);
        sel(); xb(8'h01, r); xb(8'hFF, r); desel(); wait_ready();
        rdsr(s); chk("R11 status write mask", s, 8'h9C);
        cmd1(8'h06); cmd1(8'hC7);
        rdsr(s); chk("R11 protected erase refused", s, 8'h9E);
        rd1(24'h000, d); chk("R11 protected data kept", d, 8'h77);
        sel(); xb(8'h01, r); xb(8'h00, r); desel(); wait_ready();
        rdsr(s); chk("R11 protection cleared", s, 8'h00);
        cmd1(8'h06); cmd1(8'hC7); wait_ready();
        rd1(24'h000, d); chk("R7 chip erased", d, 8'hFF);
    endtask

    task automatic t_sleep();
        logic [7:0] r, s, d;
        cmd1(8'hB9);
        rdsr(s); chk("R9 status ignored asleep", {7'd0, last_oe}, 8'h00);
        sel(); xb(8'h9F, r); xb(0, d); desel();
        chk("R9 id ignored asleep", {7'd0, last_oe}, 8'h00);
        sel(); xb(8'hAB, r); addr3(24'h0); xb(0, d); desel();
        chk("R9 wake opcode gives id", d, DEV);
        rdsr(s); chk("R9 still waking", {7'd0, last_oe}, 8'h00);
        wclk(250);
        rdsr(s); chk("R9 awake status", s, 8'h00);
        chk("R9 awake drives", {7'd0, last_oe}, 8'h01);
    endtask

    task automatic t_unknown();
        logic [7:0] r, s;
        sel(); xb(8'hFF, r); xb(8'h00, r); desel();
        chk("R1 unknown opcode silent", {7'd0, last_oe}, 8'h00);
        rdsr(s); chk("R1 unknown opcode no effect", s, 8'h00);
    endtask

    task automatic t_mode3();
        logic [7:0] r, d;
        idle_lvl = 1'b1; sck = 1'b1; wclk(8);
        sel(); xb(8'h9F, r); xb(0, d); desel();
        chk("R12 high idle clock", d, 8'hEF);
        idle_lvl = 1'b0; sck = 1'b0; wclk(8);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        wclk(5); rst_n = 1'b1; wclk(5);
        t_reset();
        t_ids();
        t_latch();
        t_program();
        t_reads();
        t_partial_prog();
        t_erase_protect();
        t_sleep();
        t_unknown();
        t_mode3();
        finish_run();
    end
endmodule